// File: doc/BRIEF.md
# Lock-Step Graph Step Sequencer

This controller drives a group of local graph processing engines through a series of lock-step graph steps. Each step runs four phases in a fixed order. First the engines take in messages. Next the controller waits at a global barrier until every engine reports that its inbound traffic is drained and the network counter shows no message still in transit. Then every engine updates its node state for a single cycle. Last, the engines emit their outbound messages. No node can update before every message of the step has been consumed, so the result does not depend on how nodes are spread across the engines. A node updates from whichever of its inputs delivered a message and never waits for a particular one.

A run begins when a start pulse arrives while the block is idle. The start pulse carries the number of steps to run. The block counts finished steps and ends the run with a one-cycle done pulse. Two global operations are built in. A broadcast request made during a step fires a single method pulse, with its target engine mask, in that step's update cycle. A reduce operation combines one 16-bit operand from each engine, using either maximum or sum. The operands are sampled when the barrier releases, and the result is valid in the update cycle that follows.

Top module: `graph_step_seq`

## Requirements
- R1: After reset the phase output reads idle (code 0), all per-engine enables are low, and done_o, bcast_o and red_vld_o are low.
- R2: A start pulse while idle with a nonzero step count moves the phase to receive (code 1) on the next clock, with recv_en_o high for every engine. With a count of zero, done_o pulses on the next clock and the phase stays idle.
- R3: The receive phase moves to barrier (code 2) only on the clock after recv_done_i is high for every engine.
- R4: The barrier releases to update (code 3) only when every recv_done_i bit is high and inflight_i is zero in the same cycle. Update lasts exactly one cycle with upd_en_o high for all engines. No update enable is ever high unless the release condition held on the previous cycle.
- R5: After update the phase is send (code 4), with send_en_o high for all engines, until send_done_i is high for every engine.
- R6: Each completed send phase increments step_idx_o. After the programmed number of steps, the block returns to idle and done_o is high for exactly one cycle. Otherwise the next step re-enters receive.
- R7: red_vld_o pulses in the update cycle. red_res_o is then the unsigned maximum (op 0) or the sum modulo 2^16 (op 1) of the 16-bit operands, where engine e's operand sits at bits [16e+15:16e]. The operands are sampled in the release cycle. The operator is latched at start.
- R8: A broadcast request made during receive or barrier makes bcast_o pulse in that step's update cycle, with bcast_mask_o equal to the last requested mask. If a step has no request, bcast_o stays low and bcast_mask_o stays zero.
- R9: A start pulse during a run is ignored: the run keeps its original step count.
- R10: The receive, update and send enable groups are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start a run (accepted only while idle) |
| step_count_i | input | CNT_W | Number of steps to run |
| red_op_i | input | 1 | Reduce operator: 0 max, 1 sum |
| recv_done_i | input | N_ENG | Per-engine inbound drained |
| send_done_i | input | N_ENG | Per-engine outbound finished |
| inflight_i | input | MSG_W | Messages still in the network |
| red_val_i | input | N_ENG*DATA_W | Per-engine reduce operands |
| bcast_req_i | input | 1 | Broadcast request |
| bcast_mask_i | input | N_ENG | Target engines of the broadcast |
| phase_o | output | 3 | Current phase code |
| recv_en_o | output | N_ENG | Receive enables |
| upd_en_o | output | N_ENG | Update enables |
| send_en_o | output | N_ENG | Send enables |
| step_idx_o | output | CNT_W | Completed steps in this run |
| done_o | output | 1 | Run finished pulse |
| bcast_o | output | 1 | Broadcast method pulse |
| bcast_mask_o | output | N_ENG | Broadcast target mask |
| red_vld_o | output | 1 | Reduce result valid |
| red_res_o | output | DATA_W | Reduce result |

## Verification
Three events fall on the same cycle: the barrier release, the reduce result and the broadcast pulse all land in the single update cycle. The bench requests a broadcast on alternate steps. It holds inflight_i nonzero, and at one point drops a done flag, so that the release happens only when the bench chooses. In that one update cycle it then checks upd_en_o, red_vld_o with the arithmetically computed max or wrapped sum, and the broadcast pulse or its absence.

// File: rtl/gs_pkg.sv
package gs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RECV = 3'd1,
    PH_BARR = 3'd2,
    PH_UPD  = 3'd3,
    PH_SEND = 3'd4
  } phase_e;

  typedef enum logic {
    RED_MAX = 1'b0,
    RED_SUM = 1'b1
  } red_op_e;
endpackage

// File: rtl/gs_phase_fsm.sv
module gs_phase_fsm
  import gs_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   start_i,
  input  logic   zero_cnt_i,
  input  logic   all_recv_i,
  input  logic   net_idle_i,
  input  logic   all_send_i,
  input  logic   last_step_i,
  output phase_e phase_o,
  output logic   start_acc_o,
  output logic   release_o,
  output logic   step_end_o,
  output logic   done_o
);
  phase_e phase_q, phase_d;
  logic   done_q, done_d;

  assign start_acc_o = (phase_q == PH_IDLE) && start_i;
  assign release_o   = (phase_q == PH_BARR) && all_recv_i && net_idle_i;
  assign step_end_o  = (phase_q == PH_SEND) && all_send_i;

  always_comb begin
    phase_d = phase_q;
    done_d  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i && zero_cnt_i) done_d = 1'b1;
        else if (start_i)          phase_d = PH_RECV;
      end
      PH_RECV: if (all_recv_i) phase_d = PH_BARR;
      PH_BARR: if (release_o)  phase_d = PH_UPD;
      PH_UPD:  phase_d = PH_SEND;
      PH_SEND: begin
        if (step_end_o) begin
          phase_d = last_step_i ? PH_IDLE : PH_RECV;
          done_d  = last_step_i;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= done_d;
    end
  end

  assign phase_o = phase_q;
  assign done_o  = done_q;
endmodule

// File: rtl/gs_step_ctr.sv
module gs_step_ctr #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] idx_o,
  output logic             last_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] limit_q, idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      limit_q <= '0;
      idx_q   <= '0;
    end else if (load_i) begin
      limit_q <= limit_i;
      idx_q   <= '0;
    end else if (inc_i) begin
      idx_q <= idx_q + CNT_W'(1);
    end
  end

  assign zero_o = (limit_i == '0);
  assign last_o = (idx_q == limit_q - CNT_W'(1));
  assign idx_o  = idx_q;
endmodule

// File: rtl/gs_reduce.sv
module gs_reduce
  import gs_pkg::*;
#(
  parameter int N_ENG  = 4,
  parameter int DATA_W = 16,
  localparam int VAL_W = N_ENG * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_op_i,
  input  logic              op_i,
  input  logic              capture_i,
  input  logic [VAL_W-1:0]  vals_i,
  output logic              vld_o,
  output logic [DATA_W-1:0] res_o
);
  red_op_e             op_q;
  logic [DATA_W-1:0]   acc_max, acc_sum, v;
  logic                vld_q;
  logic [DATA_W-1:0]   res_q;

  always_comb begin
    acc_max = '0;
    acc_sum = '0;
    v       = '0;
    for (int e = 0; e < N_ENG; e++) begin
      v = vals_i[e*DATA_W +: DATA_W];
      if (v > acc_max) acc_max = v;
      acc_sum = acc_sum + v;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_q  <= RED_MAX;
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      if (load_op_i) op_q <= red_op_e'(op_i);
      vld_q <= capture_i;
      if (capture_i) res_q <= (op_q == RED_SUM) ? acc_sum : acc_max;
    end
  end

  assign vld_o = vld_q;
  assign res_o = res_q;
endmodule

// File: rtl/gs_bcast.sv
module gs_bcast #(
  parameter int N_ENG = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             collect_i,
  input  logic             fire_i,
  input  logic             req_i,
  input  logic [N_ENG-1:0] mask_i,
  output logic             bcast_o,
  output logic [N_ENG-1:0] mask_o
);
  logic             pend_q;
  logic [N_ENG-1:0] mask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      mask_q <= '0;
    end else if (collect_i && req_i) begin
      pend_q <= 1'b1;
      mask_q <= mask_i;
    end else if (fire_i) begin
      pend_q <= 1'b0;
    end
  end

  assign bcast_o = fire_i && pend_q;
  assign mask_o  = bcast_o ? mask_q : '0;
endmodule

// File: rtl/graph_step_seq.sv
module graph_step_seq
  import gs_pkg::*;
#(
  parameter int N_ENG  = 4,
  parameter int CNT_W  = 8,
  parameter int MSG_W  = 8,
  parameter int DATA_W = 16,
  localparam int VAL_W = N_ENG * DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  step_count_i,
  input  logic              red_op_i,
  input  logic [N_ENG-1:0]  recv_done_i,
  input  logic [N_ENG-1:0]  send_done_i,
  input  logic [MSG_W-1:0]  inflight_i,
  input  logic [VAL_W-1:0]  red_val_i,
  input  logic              bcast_req_i,
  input  logic [N_ENG-1:0]  bcast_mask_i,
  output logic [2:0]        phase_o,
  output logic [N_ENG-1:0]  recv_en_o,
  output logic [N_ENG-1:0]  upd_en_o,
  output logic [N_ENG-1:0]  send_en_o,
  output logic [CNT_W-1:0]  step_idx_o,
  output logic              done_o,
  output logic              bcast_o,
  output logic [N_ENG-1:0]  bcast_mask_o,
  output logic              red_vld_o,
  output logic [DATA_W-1:0] red_res_o
);
  phase_e phase;
  logic   start_acc, release_ev, step_end, last_step, zero_cnt;

  gs_phase_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .zero_cnt_i  (zero_cnt),
    .all_recv_i  (&recv_done_i),
    .net_idle_i  (inflight_i == '0),
    .all_send_i  (&send_done_i),
    .last_step_i (last_step),
    .phase_o     (phase),
    .start_acc_o (start_acc),
    .release_o   (release_ev),
    .step_end_o  (step_end),
    .done_o      (done_o)
  );

  gs_step_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (start_acc),
    .limit_i (step_count_i),
    .inc_i   (step_end),
    .idx_o   (step_idx_o),
    .last_o  (last_step),
    .zero_o  (zero_cnt)
  );

  gs_reduce #(.N_ENG(N_ENG), .DATA_W(DATA_W)) u_red (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_op_i (start_acc),
    .op_i      (red_op_i),
    .capture_i (release_ev),
    .vals_i    (red_val_i),
    .vld_o     (red_vld_o),
    .res_o     (red_res_o)
  );

  gs_bcast #(.N_ENG(N_ENG)) u_bc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .collect_i (phase == PH_RECV || phase == PH_BARR),
    .fire_i    (phase == PH_UPD),
    .req_i     (bcast_req_i),
    .mask_i    (bcast_mask_i),
    .bcast_o   (bcast_o),
    .mask_o    (bcast_mask_o)
  );

  // receive stays open through the barrier so late messages still drain
  assign recv_en_o = {N_ENG{phase == PH_RECV || phase == PH_BARR}};
  assign upd_en_o  = {N_ENG{phase == PH_UPD}};
  assign send_en_o = {N_ENG{phase == PH_SEND}};
  assign phase_o   = phase;
endmodule

// File: rtl/gs_checker.sv
module gs_checker #(
  parameter int N_ENG  = 4,
  parameter int MSG_W  = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_ENG-1:0] recv_done_i,
  input logic [MSG_W-1:0] inflight_i,
  input logic [2:0]       phase_o,
  input logic [N_ENG-1:0] recv_en_o,
  input logic [N_ENG-1:0] upd_en_o,
  input logic [N_ENG-1:0] send_en_o,
  input logic             done_o,
  input logic             bcast_o,
  input logic             red_vld_o
);
  a_r4_no_upd_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|upd_en_o) |-> $past((&recv_done_i) && (inflight_i == '0)));

  a_r4_upd_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|upd_en_o) |=> !(|upd_en_o));

  a_r10_one_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({|recv_en_o, |upd_en_o, |send_en_o}));

  a_r3_barrier_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd2 && $past(phase_o) == 3'd1) |-> $past(&recv_done_i));

  a_r7_red_with_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    red_vld_o == (|upd_en_o));

  a_r8_bcast_in_upd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bcast_o |-> (|upd_en_o));

  a_r6_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (phase_o == 3'd0) && !(|send_en_o));
endmodule

bind graph_step_seq gs_checker #(.N_ENG(N_ENG), .MSG_W(MSG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .recv_done_i (recv_done_i),
  .inflight_i  (inflight_i),
  .phase_o     (phase_o),
  .recv_en_o   (recv_en_o),
  .upd_en_o    (upd_en_o),
  .send_en_o   (send_en_o),
  .done_o      (done_o),
  .bcast_o     (bcast_o),
  .red_vld_o   (red_vld_o)
);

// File: tb/graph_step_seq_tb.sv
module graph_step_seq_tb;
  localparam int N = 4;
  localparam int CW = 8;
  localparam int MW = 8;
  localparam int DW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [CW-1:0] step_count_i = '0;
  logic          red_op_i = 1'b0;
  logic [N-1:0]  recv_done_i = '0;
  logic [N-1:0]  send_done_i = '0;
  logic [MW-1:0] inflight_i = '0;
  logic [N*DW-1:0] red_val_i = '0;
  logic          bcast_req_i = 1'b0;
  logic [N-1:0]  bcast_mask_i = '0;
  logic [2:0]    phase_o;
  logic [N-1:0]  recv_en_o, upd_en_o, send_en_o, bcast_mask_o;
  logic [CW-1:0] step_idx_o;
  logic          done_o, bcast_o, red_vld_o;
  logic [DW-1:0] red_res_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  graph_step_seq #(.N_ENG(N), .CNT_W(CW), .MSG_W(MW), .DATA_W(DW)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] opnd(int s, int e, int k, int op);
    return DW'((s * 4099 + e * 16411 + k * 257 + op * 7 + 40000) & 16'hFFFF);
  endfunction

  task automatic run_case(input int k, input int op, input bit busy_start);
    int exp_red;
    logic [N-1:0] m;
    @(negedge clk_i);
    start_i = 1'b1; step_count_i = CW'(k); red_op_i = op[0];
    @(negedge clk_i);
    start_i = 1'b0;
    if (k == 0) begin
      chk("R2 zero-count done", done_o, 1);
      chk("R2 zero-count idle", phase_o, 0);
      @(negedge clk_i);
      chk("R6 done one cycle", done_o, 0);
      return;
    end
    chk("R2 enter receive", phase_o, 1);
    chk("R2 recv_en", recv_en_o, 4'hF);
    for (int s = 0; s < k; s++) begin
      m = N'((s * 5 + k * 3 + 1) & 4'hF);
      if (m == 0) m = 4'h9;
      inflight_i = 8'd3;
      bcast_req_i = (s % 2 == 0);
      bcast_mask_i = m;
      for (int e = 0; e < N; e++) begin
        recv_done_i[e] = 1'b1;
        @(negedge clk_i);
        bcast_req_i = 1'b0;
        if (e < N - 1) chk("R3 wait all recv", phase_o, 1);
      end
      chk("R3 barrier entered", phase_o, 2);
      for (int w = 0; w < 2; w++) begin
        if (busy_start && w == 0) begin
          start_i = 1'b1; step_count_i = 8'd1;
        end
        @(negedge clk_i);
        start_i = 1'b0;
        chk("R4 held by inflight", phase_o, 2);
        chk("R4 no update", upd_en_o, 0);
      end
      recv_done_i[1] = 1'b0; inflight_i = '0;
      @(negedge clk_i);
      chk("R4 held by done flag", phase_o, 2);
      recv_done_i = '1;
      exp_red = 0;
      for (int e = 0; e < N; e++) begin
        red_val_i[e*DW +: DW] = opnd(s, e, k, op);
        if (op == 1) exp_red = (exp_red + int'(opnd(s, e, k, op))) & 16'hFFFF;
        else if (int'(opnd(s, e, k, op)) > exp_red) exp_red = int'(opnd(s, e, k, op));
      end
      @(negedge clk_i);
      chk("R4 update", phase_o, 3);
      chk("R4 upd_en", upd_en_o, 4'hF);
      chk("R7 red_vld", red_vld_o, 1);
      chk("R7 red_res", red_res_o, exp_red);
      chk("R8 bcast", bcast_o, (s % 2 == 0));
      chk("R8 bcast mask", bcast_mask_o, (s % 2 == 0) ? m : 0);
      recv_done_i = '0;
      red_val_i = '0;
      @(negedge clk_i);
      chk("R5 send", phase_o, 4);
      chk("R5 send_en", send_en_o, 4'hF);
      chk("R4 single update", upd_en_o, 0);
      for (int e = N - 1; e >= 0; e--) begin
        send_done_i[e] = 1'b1;
        @(negedge clk_i);
        if (e > 0) chk("R5 wait all send", phase_o, 4);
      end
      send_done_i = '0;
      if (s == k - 1) begin
        chk("R6 back to idle", phase_o, 0);
        chk("R6 done pulse", done_o, 1);
      end else begin
        chk("R6 R9 next step", phase_o, 1);
        chk("R6 no early done", done_o, 0);
      end
      chk("R6 step index", step_idx_o, s + 1);
    end
    @(negedge clk_i);
    chk("R6 done one cycle", done_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 phase idle", phase_o, 0);
    chk("R1 enables", {recv_en_o, upd_en_o, send_en_o}, 0);
    chk("R1 flags", {done_o, bcast_o, red_vld_o}, 0);
    for (int k = 0; k < 4; k++)
      for (int op = 0; op < 2; op++)
        run_case(k, op, (k == 3 && op == 0));
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule